// File: doc/BRIEF.md
# Bus Configuration Register Controller

This block is the configuration register bank that sits beside the bus sequencer of a small 8-bit controller. It holds three byte-wide registers. The first carries the bus-mode bit, the CPU-mode bit and the chip-enable pin enables. The second carries the stack page. The third carries the wait-state code and the bus-request pin enable. Its register outputs act as the select lines of the pin-function multiplexers. Each of those multiplexers chooses between a dedicated bus signal and a general-purpose port signal.

A strap input reports whether the chip runs with internal program memory (MCU mode) or without it (MPU mode), and it sets the reset values. In MPU mode the bus can never leave expansion mode. Stack-page writes are clamped to the range the current bus mode permits.

The block also drives an interrupt lockout. This signal masks every interrupt source, including the non-maskable one, until the mode register and the stack-page register have each been written at least once since reset. Each stack-page write also holds the lockout until the next instruction-boundary strobe.

Top module: `busctl_cfg_regs`

## Requirements
- R1: Reset is synchronous. Reset values in MCU mode (`mode_mcu`=1) are: offset 0 reads 0x00, offset 1 reads 0x00, offset 2 reads 0x00. In MPU mode (`mode_mcu`=0), offset 0 reads 0x81 (expansion, minimum, chip-enable 0 on) and the other two offsets read 0x00. `irq_lockout` is 1 after reset.
- R2: At offset 0, bit 7 is the bus mode (1 = expansion, 0 = single-chip) and bit 6 is the CPU mode (1 = maximum, 0 = minimum). Bits 2..0 are the chip-enable pin enables (1 = chip-enable signal, 0 = general output port). Bits 5..3 read 0. The ports `bus_expand`, `cpu_max` and `cs_en` follow the stored bits.
- R3: In MPU mode, the bus-mode bit stays 1 whatever value is written to it.
- R4: In expansion mode, a stack-page write (offset 1) stores the written value if it is at most 0x27 and stores 0x27 if it is larger. The stored value is read back unchanged.
- R5: In single-chip mode, any stack-page write stores 0x00. The bus mode that decides this is the one held before the write.
- R6: At offset 2, bit 7 is the bus-request/acknowledge pin enable (`breq_en`) and bits 6..4 are the wait-state code (`wait_sel`). Bits 3..0 read 0.
- R7: Offset 3 reads 0x00. A write to offset 3 changes no register and no output.
- R8: `irq_lockout` stays 1 until offset 0 and offset 1 have each been written at least once since reset. The order of the two writes does not matter.
- R9: A write to offset 1 sets `irq_lockout` to 1 from the next cycle. It stays 1 until an `insn_boundary` strobe arrives in a later cycle. A strobe in the same cycle as the write does not clear it.
- R10: A write takes effect at the clock edge it is presented on. `rdata` and the outputs show the old value before that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_mcu | input | 1 | Strap: 1 = MCU mode, 0 = MPU mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| insn_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| bus_expand | output | 1 | 1 = expansion bus mode |
| cpu_max | output | 1 | 1 = maximum CPU mode |
| cs_en | output | NUM_CE | Chip-enable pin function selects |
| stack_page | output | 8 | Stack page |
| wait_sel | output | 3 | Wait-state code |
| breq_en | output | 1 | Bus-request/acknowledge pin function select |
| irq_lockout | output | 1 | 1 = mask all interrupts including NMI |

## Verification
Every register result, and the lockout, changes at the edge that samples the write or strobe and is visible in the cycle that follows. `rdata` is a combinational function of `addr` and the stored state. The bench drives each write or strobe on a falling edge and releases it on the next falling edge. It then samples 1 ns later, which is exactly one rising edge after the stimulus. One directed check also samples before that edge to confirm that the old value is still held.

// File: rtl/busctl_cfg_pkg.sv
package busctl_cfg_pkg;
    localparam int DATA_W     = 8;
    localparam int WAIT_W     = 3;
    localparam int OFS_MODE   = 0;
    localparam int OFS_STACK  = 1;
    localparam int OFS_TIMING = 2;
    localparam int BIT_BUSX   = 7;
    localparam int BIT_CPUMAX = 6;
    localparam int BIT_BREQ   = 7;
    localparam int WAIT_LSB   = 4;
endpackage

// File: rtl/busctl_mode_reg.sv
module busctl_mode_reg #(
    parameter int NUM_CE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_mcu,
    input  logic              wr,
    input  logic              wr_busx,
    input  logic              wr_cpumax,
    input  logic [NUM_CE-1:0] wr_ce,
    output logic              bus_expand,
    output logic              cpu_max,
    output logic [NUM_CE-1:0] ce_en
);
    typedef struct packed {
        logic              busx;
        logic              cpumax;
        logic [NUM_CE-1:0] ce;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            // MPU strap boots into expansion with chip-enable 0 live
            st_d.busx   = ~mode_mcu;
            st_d.cpumax = 1'b0;
            st_d.ce     = '0;
            st_d.ce[0]  = ~mode_mcu;
        end else if (wr) begin
            // without internal program memory single-chip is not allowed
            st_d.busx   = wr_busx | ~mode_mcu;
            st_d.cpumax = wr_cpumax;
            st_d.ce     = wr_ce;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_expand = st_q.busx;
    assign cpu_max    = st_q.cpumax;
    assign ce_en      = st_q.ce;
endmodule

// File: rtl/busctl_stack_page.sv
module busctl_stack_page #(
    parameter int              DATA_W  = 8,
    parameter logic [DATA_W-1:0] SPP_MAX = 8'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              bus_expand,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] page
);
    typedef struct packed {
        logic [DATA_W-1:0] page;
    } page_st_t;

    page_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.page = '0;
        end else if (wr) begin
            if (!bus_expand)
                st_d.page = '0;
            else if (wdata > SPP_MAX)
                st_d.page = SPP_MAX;
            else
                st_d.page = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign page = st_q.page;
endmodule

// File: rtl/busctl_irq_lock.sv
module busctl_irq_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_mode,
    input  logic wr_stack,
    input  logic insn_boundary,
    output logic lockout
);
    typedef struct packed {
        logic seen_mode;
        logic seen_stack;
        logic post_hold;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            if (wr_mode)
                st_d.seen_mode = 1'b1;
            if (wr_stack) begin
                st_d.seen_stack = 1'b1;
                st_d.post_hold  = 1'b1;   // set wins over a same-cycle strobe
            end else if (insn_boundary) begin
                st_d.post_hold  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lockout = ~(st_q.seen_mode & st_q.seen_stack) | st_q.post_hold;
endmodule

// File: rtl/busctl_cfg_regs.sv
module busctl_cfg_regs
    import busctl_cfg_pkg::*;
#(
    parameter int              ADDR_W  = 2,
    parameter int              NUM_CE  = 3,
    parameter logic [7:0]      SPP_MAX = 8'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_mcu,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              insn_boundary,
    output logic              bus_expand,
    output logic              cpu_max,
    output logic [NUM_CE-1:0] cs_en,
    output logic [7:0]        stack_page,
    output logic [2:0]        wait_sel,
    output logic              breq_en,
    output logic              irq_lockout
);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STACK  = ADDR_W'(OFS_STACK);
    localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(OFS_TIMING);

    logic wr_mode, wr_stack, wr_timing;

    assign wr_mode   = wr_en && (addr == A_MODE);
    assign wr_stack  = wr_en && (addr == A_STACK);
    assign wr_timing = wr_en && (addr == A_TIMING);

    busctl_mode_reg #(.NUM_CE(NUM_CE)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_mcu   (mode_mcu),
        .wr         (wr_mode),
        .wr_busx    (wdata[BIT_BUSX]),
        .wr_cpumax  (wdata[BIT_CPUMAX]),
        .wr_ce      (wdata[NUM_CE-1:0]),
        .bus_expand (bus_expand),
        .cpu_max    (cpu_max),
        .ce_en      (cs_en)
    );

    busctl_stack_page #(.DATA_W(DATA_W), .SPP_MAX(SPP_MAX)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_stack),
        .bus_expand (bus_expand),
        .wdata      (wdata),
        .page       (stack_page)
    );

    busctl_irq_lock u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_mode       (wr_mode),
        .wr_stack      (wr_stack),
        .insn_boundary (insn_boundary),
        .lockout       (irq_lockout)
    );

    typedef struct packed {
        logic              breq;
        logic [WAIT_W-1:0] wsel;
    } timing_st_t;

    timing_st_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (!rst_n) begin
            tm_d = '0;
        end else if (wr_timing) begin
            tm_d.breq = wdata[BIT_BREQ];
            tm_d.wsel = wdata[WAIT_LSB +: WAIT_W];
        end
    end

    always_ff @(posedge clk) begin
        tm_q <= tm_d;
    end

    assign breq_en  = tm_q.breq;
    assign wait_sel = tm_q.wsel;

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: begin
                rdata[BIT_BUSX]   = bus_expand;
                rdata[BIT_CPUMAX] = cpu_max;
                rdata[NUM_CE-1:0] = cs_en;
            end
            A_STACK:  rdata = stack_page;
            A_TIMING: begin
                rdata[BIT_BREQ]             = tm_q.breq;
                rdata[WAIT_LSB +: WAIT_W]   = tm_q.wsel;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/busctl_cfg_chk.sv
module busctl_cfg_chk #(
    parameter int         ADDR_W  = 2,
    parameter int         NUM_CE  = 3,
    parameter logic [7:0] SPP_MAX = 8'h27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_mcu,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              insn_boundary,
    input logic              bus_expand,
    input logic [NUM_CE-1:0] cs_en,
    input logic [7:0]        stack_page,
    input logic [2:0]        wait_sel,
    input logic              breq_en,
    input logic              irq_lockout
);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STACK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SPARE = ADDR_W'(3);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_lockout && stack_page == 8'h00 && !breq_en
                          && wait_sel == 3'd0 && bus_expand == !mode_mcu));

    a_r3_mpu_expand: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_mcu |-> bus_expand);

    a_r4_page_limit: assert property (@(posedge clk) disable iff (!rst_n)
        stack_page <= SPP_MAX);

    a_r5_single_chip_page: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STACK && !bus_expand) |=> stack_page == 8'h00);

    a_r7_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SPARE) |=> ($stable(stack_page) && $stable(cs_en)
                                         && $stable(breq_en) && $stable(wait_sel)));

    a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_lockout) |-> ($past(insn_boundary) || $past(wr_en && addr == A_MODE)));

    a_r9_stack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STACK) |=> irq_lockout);
endmodule

bind busctl_cfg_regs busctl_cfg_chk #(
    .ADDR_W(ADDR_W), .NUM_CE(NUM_CE), .SPP_MAX(SPP_MAX)
) u_chk (.*);

// File: tb/sim_busctl_cfg_regs.sv
module sim_busctl_cfg_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_mcu = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       insn_boundary = 1'b0;
    logic       bus_expand, cpu_max, breq_en, irq_lockout;
    logic [2:0] cs_en, wait_sel;
    logic [7:0] stack_page;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    busctl_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .mode_mcu(mode_mcu), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .insn_boundary(insn_boundary),
        .bus_expand(bus_expand), .cpu_max(cpu_max), .cs_en(cs_en),
        .stack_page(stack_page), .wait_sel(wait_sel), .breq_en(breq_en),
        .irq_lockout(irq_lockout)
    );

    // {req, addr, wdata, expected readback}
    localparam logic [21:0] VEC [0:10] = '{
        {4'd2,  2'd0, 8'h87, 8'h87},   // R2 expansion, minimum, all chip-enables
        {4'd4,  2'd1, 8'h15, 8'h15},   // R4 in range
        {4'd4,  2'd1, 8'h27, 8'h27},   // R4 limit
        {4'd4,  2'd1, 8'h28, 8'h27},   // R4 just above
        {4'd4,  2'd1, 8'hFF, 8'h27},   // R4 far above
        {4'd6,  2'd2, 8'hF0, 8'hF0},   // R6 all set
        {4'd6,  2'd2, 8'h5A, 8'h50},   // R6 low nibble reads 0
        {4'd2,  2'd0, 8'h45, 8'h45},   // R2 single-chip, maximum, ce 101
        {4'd5,  2'd1, 8'h10, 8'h00},   // R5 single-chip page forced 0
        {4'd2,  2'd0, 8'h3F, 8'h07},   // R2 bits 5..3 read 0
        {4'd7,  2'd3, 8'hAA, 8'h00}    // R7 spare offset
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mcu);
        @(negedge clk);
        rst_n = 1'b0; mode_mcu = mcu; wr_en = 1'b0; insn_boundary = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a);
        addr = a;
        #1;
    endtask

    task automatic strobe();
        @(negedge clk);
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1 MCU reset
        do_reset(1'b1);
        rd(2'd0); chk("R1", rdata, 8'h00);
        rd(2'd1); chk("R1", rdata, 8'h00);
        rd(2'd2); chk("R1", rdata, 8'h00);
        chk("R1", {7'd0, irq_lockout}, 8'h01);

        // R8 stack first, strobe, then mode
        wr(2'd1, 8'h00);
        chk("R8", {7'd0, irq_lockout}, 8'h01);
        strobe();
        chk("R8", {7'd0, irq_lockout}, 8'h01);
        wr(2'd0, 8'h87);
        chk("R8", {7'd0, irq_lockout}, 8'h00);
        chk("R2", {4'd0, bus_expand, cpu_max, cs_en[1:0]}, {4'd0, 1'b1, 1'b0, 2'b11});
        chk("R2", {5'd0, cs_en}, 8'h07);

        // R10 old value before the edge, new after; R6 ports
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd2; wdata = 8'hF0;
        #1;
        chk("R10", {7'd0, breq_en}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R10", {7'd0, breq_en}, 8'h01);
        chk("R6", {5'd0, wait_sel}, 8'h07);
        chk("R9", {7'd0, irq_lockout}, 8'h00);

        // R9 same-cycle strobe does not clear
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd1; wdata = 8'h05; insn_boundary = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; insn_boundary = 1'b0;
        #1;
        chk("R9", {7'd0, irq_lockout}, 8'h01);
        @(negedge clk);
        #1;
        chk("R9", {7'd0, irq_lockout}, 8'h01);
        strobe();
        chk("R9", {7'd0, irq_lockout}, 8'h00);

        // R1 and R3 in MPU mode
        do_reset(1'b0);
        rd(2'd0); chk("R1", rdata, 8'h81);
        chk("R1", {5'd0, cs_en}, 8'h01);
        chk("R1", {7'd0, irq_lockout}, 8'h01);
        wr(2'd0, 8'h00);
        rd(2'd0); chk("R3", rdata, 8'h80);
        chk("R3", {7'd0, bus_expand}, 8'h01);
        wr(2'd1, 8'h30);
        rd(2'd1); chk("R4", rdata, 8'h27);
        chk("R4", stack_page, 8'h27);

        // vector table in MCU mode
        do_reset(1'b1);
        for (int i = 0; i <= 10; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16]);
            n_vec++;
            if (rdata !== VEC[i][7:0]) begin
                n_bad++;
                $display("FAIL R%0d vector %0d actual=%02h expected=%02h",
                         VEC[i][21:18], i, rdata, VEC[i][7:0]);
            end
        end
        // R7 other registers untouched by the spare write
        rd(2'd0); chk("R7", rdata, 8'h07);
        rd(2'd2); chk("R7", rdata, 8'h50);
        chk("R5", stack_page, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule